// File: doc/BRIEF.md
# Single-Level Page Table Walk Translator

This block turns a 14-bit virtual address into a 12-bit physical address by fetching one 16-bit translation entry from a table held in memory. A requester presents the virtual address with its access kind (load or store) and privilege level. The block forms the entry address from a table base value and the virtual page number, issues one read on a simple memory port, and waits for as many cycles as the memory needs. It then judges the entry and returns either a physical address or a fault code.

Pages are 64 bytes, so the low six bits pass through unchanged and the upper eight bits select one of 256 entries. Entry layout: bit 15 present, bit 14 privileged-only, bit 13 store allowed, bit 12 load allowed, bits 5:0 physical frame number, bits 11:6 reserved and ignored. The block only reports faults; it never modifies the table. One walk is handled at a time.

Top module: `ptw_translator`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_rd_en` are 0.
- R2: Each accepted request produces exactly one memory read: `mem_rd_en` is high for a single cycle with `mem_rd_addr` = (`pt_base` + 2 × vaddr[13:6]) mod 4096, using the base present when the request was accepted.
- R3: The walk waits any number of cycles for `mem_rd_valid`; data is taken only when `mem_rd_valid` is high after the read, and `rsp_valid` rises exactly two cycles after the clock edge that samples it.
- R4: For an allowed access, `rsp_fault` is 00 and `rsp_paddr` = {entry[5:0], vaddr[5:0]}.
- R5: If entry bit 15 is 0, `rsp_fault` is 01 and `rsp_paddr` is 0, whatever the permission bits hold.
- R6: For a present entry, a load (`req_write`=0) needs entry bit 12 and a store (`req_write`=1) needs entry bit 13; otherwise `rsp_fault` is 10 and `rsp_paddr` is 0. Code 11 never appears.
- R7: A present entry with bit 14 set, accessed with `req_super`=0, gives `rsp_fault` 10; with `req_super`=1 only the load/store bits decide.
- R8: A request is taken only while `req_ready` is 1; `req_ready` is 0 from the cycle after acceptance until the cycle after the response, requests offered in that time are ignored, and `rsp_valid` lasts one cycle.

Ports table below follows the port list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pt_base | input | 12 | Byte address of the current table |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_vaddr | input | 14 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_super | input | 1 | 1 = privileged requester |
| mem_rd_en | output | 1 | One-cycle entry read strobe |
| mem_rd_addr | output | 12 | Entry byte address |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 16 | Entry contents |
| rsp_valid | output | 1 | Result present (one cycle) |
| rsp_paddr | output | 12 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 permission |

## Verification
Directed walks cover each fault class on its own: an absent entry with full permissions (separates presence from permission priority), a store to a load-only page, a privileged page from both levels, and a request held high through a busy walk. Randomized walks then draw the table contents, the base, the address, the access kind and the memory latency (one to six cycles) independently, so a wrong entry address, a swapped load/store bit, a dropped privilege test or a miscounted wait shows up as a mismatch against the bench's own model. Garbage is driven on the read data whenever it is not marked valid, which exposes early capture.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 14;
  localparam int PA_W   = 12;
  localparam int OFF_W  = 6;
  localparam int PTE_W  = 16;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int ENTRY_BYTES_LOG2 = 1;

  localparam int B_PRESENT = 15;
  localparam int B_PRIV    = 14;
  localparam int B_STORE   = 13;
  localparam int B_LOAD    = 12;

  typedef enum logic [1:0] {
    FLT_OK   = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_CHECK, ST_RESPOND
  } walk_st_e;

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                 input logic [VPN_W-1:0] vpn);
    logic [PA_W-1:0] scaled;
    scaled = PA_W'(vpn) << ENTRY_BYTES_LOG2;
    return base + scaled;
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction
endpackage

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     mem_rd_valid,
  output walk_st_e st,
  output logic     req_ready,
  output logic     mem_rd_en,
  output logic     rsp_valid,
  output logic     ev_accept,
  output logic     ev_take,
  output logic     ev_check
);
  walk_st_e st_nxt;

  assign ev_accept = (st == ST_IDLE) && req_valid;
  assign ev_take   = (st == ST_WAIT) && mem_rd_valid;
  assign ev_check  = (st == ST_CHECK);
  assign req_ready = (st == ST_IDLE);
  assign mem_rd_en = (st == ST_FETCH);
  assign rsp_valid = (st == ST_RESPOND);

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE:    if (req_valid)    st_nxt = ST_FETCH;
      ST_FETCH:                     st_nxt = ST_WAIT;
      ST_WAIT:    if (mem_rd_valid) st_nxt = ST_CHECK;
      ST_CHECK:                     st_nxt = ST_RESPOND;
      ST_RESPOND:                   st_nxt = ST_IDLE;
      default:                      st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  AST_ACCEPT_READS:   assert property (@(posedge clk) disable iff (!rst_n) ev_accept |=> mem_rd_en);              // R2
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |=> !mem_rd_en);             // R2
  AST_TAKE_TO_RSP:    assert property (@(posedge clk) disable iff (!rst_n) ev_take |=> ##1 rsp_valid);            // R3
  AST_RSP_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);             // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid || mem_rd_en) |-> !req_ready); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ev_accept |=> !req_ready);             // R8
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  logic             acc_store,
  input  logic             acc_priv,
  output fault_e           fault,
  output logic [PPN_W-1:0] ppn
);
  logic present, priv_only, may_store, may_load, perm_ok;
  logic unused_rsvd;

  assign present   = pte[B_PRESENT];
  assign priv_only = pte[B_PRIV];
  assign may_store = pte[B_STORE];
  assign may_load  = pte[B_LOAD];
  assign ppn       = pte[PPN_W-1:0];
  assign unused_rsvd = ^pte[B_LOAD-1:PPN_W];

  assign perm_ok = (!priv_only || acc_priv) && (acc_store ? may_store : may_load);

  always_comb begin
    if (!present)      fault = FLT_PAGE;
    else if (!perm_ok) fault = FLT_PROT;
    else               fault = FLT_OK;
  end
endmodule

// File: rtl/ptw_translator.sv
module ptw_translator
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_super,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault
);
  walk_st_e         st;
  logic             ev_accept, ev_take, ev_check;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic             store_q, priv_q;
  logic [PTE_W-1:0] pte_q;
  fault_e           chk_fault, fault_q;
  logic [PPN_W-1:0] chk_ppn;
  logic [PA_W-1:0]  pa_q;

  ptw_walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_rd_valid(mem_rd_valid),
    .st(st), .req_ready(req_ready), .mem_rd_en(mem_rd_en), .rsp_valid(rsp_valid),
    .ev_accept(ev_accept), .ev_take(ev_take), .ev_check(ev_check)
  );

  ptw_entry_check u_check (
    .pte(pte_q), .acc_store(store_q), .acc_priv(priv_q),
    .fault(chk_fault), .ppn(chk_ppn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      base_q  <= '0;
      store_q <= 1'b0;
      priv_q  <= 1'b0;
    end else if (ev_accept) begin
      va_q    <= req_vaddr;
      base_q  <= pt_base;
      store_q <= req_write;
      priv_q  <= req_super;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pte_q <= '0;
    else if (ev_take) pte_q <= mem_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FLT_OK;
      pa_q    <= '0;
    end else if (ev_check) begin
      fault_q <= chk_fault;
      pa_q    <= (chk_fault == FLT_OK) ? join_pa(chk_ppn, va_q[OFF_W-1:0]) : '0;
    end
  end

  assign mem_rd_addr = entry_addr(base_q, va_q[VA_W-1:OFF_W]);
  assign rsp_paddr   = pa_q;
  assign rsp_fault   = fault_q;

  AST_PF_ZERO_PA:   assert property (@(posedge clk) disable iff (!rst_n)
                      (rsp_valid && rsp_fault != FLT_OK) |-> rsp_paddr == '0);                 // R5
  AST_ABSENT_PF:    assert property (@(posedge clk) disable iff (!rst_n)
                      (rsp_valid && !pte_q[B_PRESENT]) |-> rsp_fault == FLT_PAGE);             // R5
  AST_NO_CODE3:     assert property (@(posedge clk) disable iff (!rst_n)
                      rsp_valid |-> rsp_fault != 2'b11);                                       // R6
  AST_PRIV_USER:    assert property (@(posedge clk) disable iff (!rst_n)
                      (rsp_valid && pte_q[B_PRIV] && !priv_q) |-> rsp_fault != FLT_OK);        // R7
  AST_OFFSET_KEPT:  assert property (@(posedge clk) disable iff (!rst_n)
                      (rsp_valid && rsp_fault == FLT_OK) |-> rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]); // R4
  AST_ADDR_HELD:    assert property (@(posedge clk) disable iff (!rst_n)
                      (st == ST_WAIT) |-> $stable(mem_rd_addr));                               // R2
endmodule

// File: tb/ptw_translator_tb.sv
module ptw_translator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pt_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_super = 1'b0;
  logic        mem_rd_en;
  logic [11:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [15:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic [11:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int tests = 0, fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ptw_translator u_dut (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_super(req_super), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  // memory model: word array indexed by addr[11:1]
  logic [15:0] mem [0:2047];
  int          lat = 1;
  int          cnt = 0;
  bit          pending = 0;
  int          rd_count = 0;
  logic [11:0] last_addr = '0;
  int          take_cyc = 0;

  always @(negedge clk) begin
    if (mem_rd_valid) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= 16'($urandom);
    end else if (pending) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        pending = 0;
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem[last_addr[11:1]];
        take_cyc = cyc;
      end else begin
        mem_rd_data <= 16'($urandom);
      end
    end
    if (mem_rd_en) begin
      rd_count++;
      last_addr = mem_rd_addr;
      pending = 1;
      cnt = lat;
    end
  end

  function automatic logic [1:0] exp_fault(logic [15:0] e, bit wr, bit sup);
    if (!e[15]) return 2'b01;
    if (e[14] && !sup) return 2'b10;
    if (wr ? !e[13] : !e[12]) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [11:0] exp_pa(logic [15:0] e, logic [13:0] va, bit wr, bit sup);
    if (exp_fault(e, wr, sup) != 2'b00) return 12'h000;
    return {e[5:0], va[5:0]};
  endfunction

  function automatic logic [11:0] exp_addr(logic [11:0] base, logic [13:0] va);
    int a;
    a = (int'(base) + 2 * int'(va[13:6])) % 4096;
    return a[11:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // hold: keep req_valid high with another address during the walk
  task automatic walk(logic [13:0] va, bit wr, bit sup, int l, bit hold);
    logic [15:0] e;
    logic [11:0] ea;
    int rc0, n;
    ea = exp_addr(pt_base, va);
    e  = mem[ea[11:1]];
    lat = l;
    rc0 = rd_count;
    @(negedge clk);
    check("R8 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_super = sup;
    @(negedge clk);
    if (hold) begin
      req_vaddr = va ^ 14'h3FC0; req_write = ~wr; req_super = ~sup;
    end else begin
      req_valid = 1'b0;
    end
    check("R8 busy after accept", 32'(req_ready), 32'd0);
    n = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    req_valid = 1'b0;
    if (n >= 100) begin
      check("R3 response arrives", 32'd0, 32'd1);
      return;
    end
    check("R2 one read per walk", 32'(rd_count - rc0), 32'd1);
    check("R2 entry address", 32'(last_addr), 32'(ea));
    check("R3 response two cycles after data", 32'(cyc - take_cyc), 32'd2);
    check(e[15] ? "R4/R6/R7 fault code" : "R5 fault code", 32'(rsp_fault), 32'(exp_fault(e, wr, sup)));
    check("R4 physical address", 32'(rsp_paddr), 32'(exp_pa(e, va, wr, sup)));
    @(negedge clk);
    check("R8 single-cycle response", 32'(rsp_valid), 32'd0);
    check("R8 ready after response", 32'(req_ready), 32'd1);
  endtask

  initial begin
    #3000000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [11:0] ea;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) mem[i] = 16'($urandom) & 16'hF03F;
    repeat (3) @(negedge clk);
    check("R1 ready at reset", 32'(req_ready), 32'd1);
    check("R1 no response at reset", 32'(rsp_valid), 32'd0);
    check("R1 no read at reset", 32'(mem_rd_en), 32'd0);
    rst_n = 1'b1;

    pt_base = 12'h200;
    ea = exp_addr(pt_base, 14'h03D4); mem[ea[11:1]] = 16'h900D;  // present, load only
    walk(14'h03D4, 1'b0, 1'b0, 1, 1'b0);                         // R4 load ok
    walk(14'h03D4, 1'b1, 1'b0, 3, 1'b0);                         // R6 store denied
    ea = exp_addr(pt_base, 14'h0B8F); mem[ea[11:1]] = 16'h7035;  // absent, all perms
    walk(14'h0B8F, 1'b0, 1'b1, 2, 1'b0);                         // R5 priority
    ea = exp_addr(pt_base, 14'h0020); mem[ea[11:1]] = 16'hF028;  // privileged page
    walk(14'h0020, 1'b0, 1'b0, 1, 1'b0);                         // R7 user denied
    walk(14'h0020, 1'b1, 1'b1, 5, 1'b0);                         // R7 privileged ok
    pt_base = 12'hF80;                                           // R2 wrap
    ea = exp_addr(pt_base, 14'h3FFF); mem[ea[11:1]] = 16'hB03F;
    walk(14'h3FFF, 1'b1, 1'b0, 4, 1'b0);
    walk(14'h1234, 1'b0, 1'b1, 6, 1'b1);                         // R8 held request ignored

    for (int k = 0; k < 400; k++) begin
      if (k % 50 == 0) pt_base = 12'($urandom) & 12'hFFE;
      walk(14'($urandom), 1'($urandom), 1'($urandom), 1 + int'($urandom % 6), (k % 7) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule